// File: doc/BRIEF.md
# Framed Serial Host Transfer Engine

This block is the master end of a synchronous serial link that uses SPI-style clocking. It carries one byte per transaction, in either direction. Every frame starts with a three-bit header: a start marker, a read/write flag and a one-bit register selector. The eight data bits follow, most significant first. The local side raises a request carrying the direction, the selector and a byte to write. It watches a busy flag, and it collects the returned byte when a one-cycle completion strobe fires.

Some peripherals start driving read data one serial clock earlier than the standard frame expects. A configuration input lets the engine work with them: it removes the selector clock from read frames, and only from read frames. Without this option such a peripheral's byte arrives shifted one place toward the MSB, and its top bit is lost. The serial clock rate and the chip-select polarity are also set by configuration inputs.

Top module: `sxfer_host`

## Requirements
- R1: `mosi` changes only on falling `sclk` edges. It starts at the header bit 1, then sends the direction bit (1 = read, 0 = write) and the selector bit. Eight data bits follow, bit 7 first: `req_wdata` for writes and zeros for reads. `mosi` is 0 when idle.
- R2: `miso` is sampled on every rising `sclk` edge. With the option off, the byte is taken from rising edges 4 to 11, MSB first.
- R3: With `cfg_read_early` set, a read frame has 10 rising edges. The selector clock is left out, so the byte is taken from rising edges 3 to 10.
- R4: A write frame always has 11 rising edges, whatever `cfg_read_early` is set to.
- R5: One half period of `sclk` is `cfg_half_div`+1 system clocks. `sclk` idles low, and a frame with N rising edges lasts (2N+1) half periods from acceptance to `done`.
- R6: `cs` is active (level equal to `cfg_cs_high`) from the cycle after acceptance. That is one half period before the first rising edge. It is released one half period after the last falling edge.
- R7: `busy` rises the cycle after a request is accepted. It falls in the same cycle as the single-cycle `done` pulse, and `rd_data` then holds the captured byte.
- R8: A request raised while `busy` is high is ignored. It starts no frame and does not alter the frame in progress.
- R9: If the option is off and the peripheral drives data one clock early, the returned byte equals the sent byte shifted left by one, with bit 0 taken from the idle line (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_div | input | DIV_W | Half-period length minus one, in system clocks |
| cfg_cs_high | input | 1 | Active level of chip select |
| cfg_read_early | input | 1 | Drop the selector clock on reads |
| req_valid | input | 1 | Transaction request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_sel | input | 1 | Register-select bit |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8 | Byte captured in the last frame |
| sclk | output | 1 | Serial clock |
| cs | output | 1 | Chip select |
| mosi | output | 1 | Serial data to peripheral |
| miso | input | 1 | Serial data from peripheral |

## Verification
The assertions check these rules on every cycle:
- `sclk` stays low when idle, and `mosi` holds still except at falling edges.
- The receive register moves only on rising edges.
- `done` is a single pulse that ends `busy`.
- Chip select becomes active right after acceptance.
- The frame length latched at acceptance matches the direction and the option, and a request made while busy cannot change it.

Other behaviour only the bench scenarios can show. This covers the bit positions where each byte is captured and the left-shifted result when an early peripheral meets standard framing. It also covers frame durations for several divider values and the effect of both chip-select polarities. The bench uses a peripheral model that drives its byte on time or one clock early.

// File: rtl/sxfer_pkg.sv
package sxfer_pkg;

    localparam int BYTE_W  = 8;
    localparam int PRE_W   = 3;
    localparam int FRAME_W = PRE_W + BYTE_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int PH_W    = $clog2(2 * FRAME_W + 2);

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    typedef struct packed {
        dir_e              dir;
        logic              sel;
        logic [BYTE_W-1:0] wdata;
    } xfer_req_t;

    // Bits to shift out, left aligned, unused tail zero.
    function automatic logic [FRAME_W-1:0] build_frame(input xfer_req_t r, input logic early);
        logic [FRAME_W-1:0] f;
        if (early && r.dir == DIR_READ)
            f = {2'b11, {(FRAME_W-2){1'b0}}};
        else if (r.dir == DIR_READ)
            f = {1'b1, 1'b1, r.sel, {BYTE_W{1'b0}}};
        else
            f = {1'b1, 1'b0, r.sel, r.wdata};
        return f;
    endfunction

    // Number of rising serial edges in the frame.
    function automatic logic [CNT_W-1:0] frame_bits(input dir_e d, input logic early);
        return (early && d == DIR_READ) ? CNT_W'(FRAME_W - 1) : CNT_W'(FRAME_W);
    endfunction

endpackage

// File: rtl/sxfer_clkdiv.sv
module sxfer_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            div_q <= div_in;
            cnt   <= '0;
        end else if (run) begin
            if (cnt == div_q) cnt <= '0;
            else              cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == div_q);

    // Half-period ticks are spaced by div_q+1 cycles.
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && div_q != '0) |=> !tick);

endmodule

// File: rtl/sxfer_seq.sv
module sxfer_seq
    import sxfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             tick,
    input  logic [CNT_W-1:0] nbits,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             rise,
    output logic             fall,
    output logic             finish
);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] end_ph;
    logic            last;

    assign end_ph = PH_W'(2 * int'(nbits));
    assign last   = (ph == end_ph);
    assign finish = busy && tick && last;
    assign rise   = busy && tick && !sclk && !last;
    assign fall   = busy && tick && sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            sclk <= 1'b0;
            ph   <= '0;
        end else begin
            done <= finish;
            if (accept) begin
                busy <= 1'b1;
                sclk <= 1'b0;
                ph   <= '0;
            end else if (busy && tick) begin
                ph <= ph + 1'b1;
                if (last) begin
                    busy <= 1'b0;
                    sclk <= 1'b0;
                end else begin
                    sclk <= ~sclk;
                end
            end
        end
    end

    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);
    p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/sxfer_shift.sv
module sxfer_shift
    import sxfer_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               rise,
    input  logic               fall,
    input  logic               miso,
    output logic               mosi,
    output logic [BYTE_W-1:0]  rx
);

    logic [FRAME_W-1:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
            rx    <= '0;
        end else begin
            if (load)      tx_sr <= frame;
            else if (fall) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
            if (load)      rx <= '0;
            else if (rise) rx <= {rx[BYTE_W-2:0], miso};
        end
    end

    assign mosi = tx_sr[FRAME_W-1];

    p_mosi_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
        (!fall && !load) |=> $stable(mosi));
    p_rx_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (!rise && !load) |=> $stable(rx));

endmodule

// File: rtl/sxfer_host.sv
module sxfer_host
    import sxfer_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic             cfg_cs_high,
    input  logic             cfg_read_early,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic             req_sel,
    input  logic [7:0]       req_wdata,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rd_data,
    output logic             sclk,
    output logic             cs,
    output logic             mosi,
    input  logic             miso
);

    xfer_req_t          req;
    logic               accept;
    logic               busy_w;
    logic               tick;
    logic               rise;
    logic               fall;
    logic               finish;
    logic [CNT_W-1:0]   nbits_q;
    logic [BYTE_W-1:0]  rx;
    logic [BYTE_W-1:0]  rd_q;

    assign req    = '{dir: (req_read ? DIR_READ : DIR_WRITE), sel: req_sel, wdata: req_wdata};
    assign accept = req_valid && !busy_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            nbits_q <= '0;
            rd_q    <= '0;
        end else begin
            if (accept) nbits_q <= frame_bits(req.dir, cfg_read_early);
            if (finish) rd_q    <= rx;
        end
    end

    sxfer_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .run    (busy_w),
        .div_in (cfg_half_div),
        .tick   (tick)
    );

    sxfer_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .tick   (tick),
        .nbits  (nbits_q),
        .busy   (busy_w),
        .done   (done),
        .sclk   (sclk),
        .rise   (rise),
        .fall   (fall),
        .finish (finish)
    );

    sxfer_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .frame (build_frame(req, cfg_read_early)),
        .rise  (rise),
        .fall  (fall),
        .miso  (miso),
        .mosi  (mosi),
        .rx    (rx)
    );

    assign busy    = busy_w;
    assign rd_data = rd_q;
    assign cs      = cfg_cs_high ? busy_w : ~busy_w;

    p_read_early_len_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && req_read && cfg_read_early) |=> nbits_q == CNT_W'(FRAME_W - 1));
    p_write_full_len_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_read) |=> nbits_q == CNT_W'(FRAME_W));
    p_cs_on_accept_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> (cs == cfg_cs_high));
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_w && req_valid) |=> $stable(nbits_q));

endmodule

// File: tb/test_sxfer_host.sv
module test_sxfer_host;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_half_div = 8'd0;
    logic       cfg_cs_high = 1'b1;
    logic       cfg_read_early = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_read = 1'b0;
    logic       req_sel = 1'b0;
    logic [7:0] req_wdata = 8'd0;
    logic       busy, done, sclk, cs, mosi;
    logic [7:0] rd_data;
    logic       miso = 1'b0;

    always #5 clk = ~clk;

    sxfer_host #(.DIV_W(8)) i_sxfer_host (
        .clk(clk), .rst(rst), .cfg_half_div(cfg_half_div), .cfg_cs_high(cfg_cs_high),
        .cfg_read_early(cfg_read_early), .req_valid(req_valid), .req_read(req_read),
        .req_sel(req_sel), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .sclk(sclk), .cs(cs), .mosi(mosi), .miso(miso)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: position in frame derived from elapsed cycles.
    bit         started = 0;
    bit         m_busy = 0, m_done = 0, m_sclk = 0, m_mosi = 0;
    logic [7:0] m_rd = 8'd0, m_rx = 8'd0;
    int         m_c = 0, m_h = 1, m_n = 0;
    bit         m_frame[$];

    always @(posedge clk) begin
        int k;
        started = 1;
        m_done  = 0;
        if (rst) begin
            m_busy = 0; m_c = 0; m_rd = 0; m_rx = 0; m_n = 0;
            m_frame.delete();
        end else if (!m_busy) begin
            if (req_valid) begin
                m_busy = 1; m_c = 0; m_h = int'(cfg_half_div) + 1;
                m_frame.delete();
                m_frame.push_back(1'b1);
                if (req_read && cfg_read_early) m_frame.push_back(1'b1);
                else begin
                    m_frame.push_back(req_read);
                    m_frame.push_back(req_sel);
                end
                for (int i = 7; i >= 0; i--) m_frame.push_back(req_read ? 1'b0 : req_wdata[i]);
                m_n = m_frame.size();
            end
        end else begin
            m_c++;
            if (m_c % m_h == 0) begin
                k = m_c / m_h;
                if (k % 2 == 1 && k < 2 * m_n + 1) m_rx = {m_rx[6:0], miso};
                if (k == 2 * m_n + 1) begin
                    m_busy = 0; m_done = 1; m_rd = m_rx;
                end
            end
        end
        k = m_busy ? m_c / m_h : 0;
        m_sclk = m_busy && (k % 2 == 1);
        m_mosi = (m_busy && (k / 2 < m_n)) ? m_frame[k / 2] : 1'b0;
    end

    always @(negedge clk) begin
        if (started) begin
            chk("R5 sclk", sclk, m_sclk);
            chk("R6 cs", cs, m_busy ? cfg_cs_high : !cfg_cs_high);
            chk("R1 mosi", mosi, m_mosi);
            chk("R7 busy", busy, m_busy);
            chk("R7 done", done, m_done);
            chk("R2 rd_data", rd_data, m_rd);
        end
    end

    // Peripheral model: byte driven after falling edge 3 (on time) or 2 (early).
    int         fcnt = 0, rises = 0;
    logic       p_prev = 1'b0;
    logic [7:0] pbyte = 8'd0;
    bit         p_early = 0;

    always @(negedge clk) begin
        int lead;
        if (cs !== cfg_cs_high) fcnt = 0;
        else if (p_prev && sclk === 1'b0) fcnt++;
        if (!p_prev && sclk === 1'b1) rises++;
        p_prev = (sclk === 1'b1);
        lead = p_early ? 2 : 3;
        miso = (fcnt >= lead && fcnt < lead + 8) ? pbyte[7 - (fcnt - lead)] : 1'b0;
    end

    task automatic xfer(input bit rd, input bit sel, input logic [7:0] wd, input logic [7:0] div,
                        input bit early_cfg, input bit early_per, input logic [7:0] pb,
                        input int hold, output logic [7:0] got, output int nrise, output int ncyc);
        int r0, n;
        @(negedge clk);
        cfg_half_div = div; cfg_read_early = early_cfg; p_early = early_per; pbyte = pb;
        req_read = rd; req_sel = sel; req_wdata = wd; req_valid = 1'b1;
        r0 = rises;
        @(negedge clk);
        n = 0;
        for (int h = 0; h < hold; h++) begin
            req_wdata = ~wd; req_read = !rd; req_sel = !sel;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        got = rd_data; nrise = rises - r0; ncyc = n;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R7: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] got;
        int nr, nc, r_before;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 reset busy", busy, 0);
        chk("R5 reset sclk", sclk, 0);
        chk("R6 reset cs", cs, 0);
        chk("R1 reset mosi", mosi, 0);

        xfer(0, 1, 8'hA5, 8'd0, 0, 0, 8'h00, 0, got, nr, nc);
        chk("R4 write rises", nr, 11);
        chk("R5 write cycles div0", nc, 23);

        xfer(1, 0, 8'h00, 8'd1, 0, 0, 8'h3C, 0, got, nr, nc);
        chk("R2 read byte std", got, 8'h3C);
        chk("R5 read cycles div1", nc, 46);

        xfer(1, 1, 8'h00, 8'd1, 1, 1, 8'h88, 0, got, nr, nc);
        chk("R3 early read byte", got, 8'h88);
        chk("R3 early read rises", nr, 10);
        chk("R3 early read cycles", nc, 42);

        xfer(1, 1, 8'h00, 8'd0, 0, 1, 8'h88, 0, got, nr, nc);
        chk("R9 shifted byte", got, 8'h10);

        xfer(0, 0, 8'h5A, 8'd2, 1, 0, 8'h00, 0, got, nr, nc);
        chk("R4 write rises with option", nr, 11);
        chk("R5 write cycles div2", nc, 69);

        @(posedge clk); #1 cfg_cs_high = 1'b0;
        @(negedge clk);
        chk("R6 idle cs low-active", cs, 1);
        xfer(1, 0, 8'h00, 8'd3, 0, 0, 8'hC1, 0, got, nr, nc);
        chk("R2 read byte div3", got, 8'hC1);
        @(negedge clk);
        chk("R6 released cs low-active", cs, 1);
        @(posedge clk); #1 cfg_cs_high = 1'b1;

        xfer(0, 1, 8'h0F, 8'd1, 0, 0, 8'h00, 4, got, nr, nc);
        chk("R8 rises with held request", nr, 11);
        r_before = rises;
        repeat (3) @(negedge clk);
        chk("R8 no second frame busy", busy, 0);
        chk("R8 no second frame rises", rises - r_before, 0);

        xfer(1, 0, 8'h00, 8'd0, 1, 1, 8'h01, 0, got, nr, nc);
        chk("R3 early read lsb only", got, 8'h01);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule